// File: doc/BRIEF.md
# DMA Request Scanner and Address Generator

This block sits beside a pair of cascaded four-channel DMA controllers. The first controller moves bytes and the second moves 16-bit words. Together they give eight global channels, numbered 0 to 7. The block turns each channel's request line into a held status bit. It walks the eight channels with a scan pointer. When the pointer reaches a channel that has a pending request and is not masked, it issues one grant. The grant reports the global channel number, the transfer length in bytes and the 31-bit physical start address of the transfer.

The block also holds the page and high-page register files. They sit behind a sparse 3-bit port offset, selected per controller, and supply the upper address bits. Once a grant has been issued, the memory-side logic supplies a position and a length. The block returns the memory start address for that piece of the transfer, and this address honours the granted channel's direction bit.

Top module: `dma_req_scan`

## Requirements
- R1: Page port offsets select a controller's channel as follows: offset 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3. A write to offset 0, 4, 5 or 6 changes no register, and a read from any of those offsets returns 0. Reads are combinational.
- R2: Each channel has an 8-bit page register and a separate 8-bit high-page register, both selected by `pg_hi_i`. The high-page file is reachable only when `HIGH_PAGE_EN` is nonzero; otherwise writes to it are dropped and reads from it return 0.
- R3: The grant address is ((high page & 0x7F) << 24) | (page << 16) | current address. It uses the page values held before the edge that issues the grant.
- R4: A channel can be granted only when its mask bit is 0 and its held request status bit is 1.
- R5: The scan pointer visits one global channel per cycle, in the order 0 to 7 (controller 0 first), and then wraps. When the pointed channel is eligible, `gnt_valid_o` pulses high for one cycle and the pointer returns to channel 0.
- R6: `gnt_chan_o` is the global channel number, local channel + 4 × controller. Bit 2 set means controller 1.
- R7: The transfer length is (base count + 1) << controller, so a count of 0xFFFF on controller 1 gives 0x20000.
- R8: A high `dreq_i[g]` sets channel g's status bit at the next clock edge, and a low level clears it at the next edge. The scan sees the new status one cycle later.
- R9: `mem_addr_o` equals the grant address − pos − len when the granted channel's decrement bit was set at grant time. Otherwise it equals the grant address + pos. The result wraps to 31 bits.
- R10: After reset there is no grant, the scan pointer is at channel 0, all status bits are clear and every page and high-page register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 8 | Request level per global channel |
| mask_i | input | 8 | Mask bit per global channel, 1 blocks service |
| dec_i | input | 8 | Address decrement bit per global channel |
| cur_addr_i | input | 8*ADDR_W | Current address per channel, channel g at bits g*ADDR_W |
| base_cnt_i | input | 8*CNT_W | Base count per channel, channel g at bits g*CNT_W |
| pg_we_i | input | 1 | Page register write strobe |
| pg_hi_i | input | 1 | 1 selects the high-page file |
| pg_ctl_i | input | 1 | Controller select for the page port |
| pg_off_i | input | 3 | Page port offset |
| pg_wdata_i | input | 8 | Page write data |
| pg_rdata_o | output | 8 | Page read data |
| xfer_pos_i | input | CNT_W+2 | Byte position inside the granted transfer |
| xfer_len_i | input | CNT_W+2 | Byte length of the current piece |
| gnt_valid_o | output | 1 | One-cycle grant strobe |
| gnt_chan_o | output | 3 | Granted global channel |
| gnt_len_o | output | CNT_W+2 | Granted transfer length in bytes |
| gnt_addr_o | output | ADDR_W+15 | Granted physical start address |
| mem_addr_o | output | ADDR_W+15 | Memory start for the current position and length |

## Verification
The assertions check on every cycle that a grant only names a channel that was unmasked with status set one edge earlier, and that the pointer always sits at channel 0 right after a grant. They also check that controller 1 lengths are even and that unmapped page offsets read 0. The scan latency as a function of channel position, the one-edge delay from a request to its status bit and the exact address and length values depend on stimulus history. Only the bench's cycle model can show those, by tracking requests, masks, page writes and the decrement path across changing patterns.

// File: rtl/dma_req_scan.sv
module dma_req_scan #(
  parameter int ADDR_W = 16,
  parameter int CNT_W = 16,
  parameter int HIGH_PAGE_EN = 1,
  localparam int LEN_W = CNT_W + 2,
  localparam int PA_W = ADDR_W + 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          dreq_i,
  input  logic [7:0]          mask_i,
  input  logic [7:0]          dec_i,
  input  logic [8*ADDR_W-1:0] cur_addr_i,
  input  logic [8*CNT_W-1:0]  base_cnt_i,
  input  logic                pg_we_i,
  input  logic                pg_hi_i,
  input  logic                pg_ctl_i,
  input  logic [2:0]          pg_off_i,
  input  logic [7:0]          pg_wdata_i,
  output logic [7:0]          pg_rdata_o,
  input  logic [LEN_W-1:0]    xfer_pos_i,
  input  logic [LEN_W-1:0]    xfer_len_i,
  output logic                gnt_valid_o,
  output logic [2:0]          gnt_chan_o,
  output logic [LEN_W-1:0]    gnt_len_o,
  output logic [PA_W-1:0]     gnt_addr_o,
  output logic [PA_W-1:0]     mem_addr_o
);

  logic [7:0] page_q [8];
  logic [7:0] hpage_q [8];
  logic [7:0] st_q;
  logic [2:0] ptr_q;
  logic       gnt_dec_q;

  // sparse page port decode
  logic       map_ok;
  logic [1:0] map_ch;
  always_comb begin
    map_ok = 1'b1;
    map_ch = 2'd0;
    case (pg_off_i)
      3'd7: map_ch = 2'd0;
      3'd3: map_ch = 2'd1;
      3'd1: map_ch = 2'd2;
      3'd2: map_ch = 2'd3;
      default: map_ok = 1'b0;
    endcase
  end
  wire [2:0] pidx = {pg_ctl_i, map_ch};
  wire hi_ok = (HIGH_PAGE_EN != 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        page_q[i]  <= '0;
        hpage_q[i] <= '0;
      end
    end else if (pg_we_i && map_ok) begin
      if (!pg_hi_i)   page_q[pidx]  <= pg_wdata_i;
      else if (hi_ok) hpage_q[pidx] <= pg_wdata_i;
    end
  end

  assign pg_rdata_o = !map_ok ? 8'd0 :
                      !pg_hi_i ? page_q[pidx] :
                      hi_ok ? hpage_q[pidx] : 8'd0;

  // scan and grant
  wire [7:0]       elig = st_q & ~mask_i;
  wire [CNT_W-1:0] cnt  = base_cnt_i[ptr_q*CNT_W +: CNT_W];
  wire [LEN_W-1:0] len  = (LEN_W'(cnt) + LEN_W'(1)) << ptr_q[2];
  wire [PA_W-1:0]  addr = {hpage_q[ptr_q][6:0], page_q[ptr_q], cur_addr_i[ptr_q*ADDR_W +: ADDR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= '0;
      ptr_q       <= '0;
      gnt_valid_o <= 1'b0;
      gnt_chan_o  <= '0;
      gnt_len_o   <= '0;
      gnt_addr_o  <= '0;
      gnt_dec_q   <= 1'b0;
    end else begin
      st_q <= dreq_i;
      if (elig[ptr_q]) begin
        gnt_valid_o <= 1'b1;
        gnt_chan_o  <= ptr_q;
        gnt_len_o   <= len;
        gnt_addr_o  <= addr;
        gnt_dec_q   <= dec_i[ptr_q];
        ptr_q       <= '0;
      end else begin
        gnt_valid_o <= 1'b0;
        ptr_q       <= ptr_q + 3'd1;
      end
    end
  end

  assign mem_addr_o = gnt_dec_q ? gnt_addr_o - PA_W'(xfer_pos_i) - PA_W'(xfer_len_i)
                                : gnt_addr_o + PA_W'(xfer_pos_i);

  p_grant_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> ((($past(elig) >> gnt_chan_o) & 8'd1) != 8'd0));

  p_restart_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> ptr_q == 3'd0);

  p_word_len_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && gnt_chan_o[2]) |-> !gnt_len_o[0]);

  p_unmapped_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_off_i == 3'd0 || pg_off_i == 3'd4 || pg_off_i == 3'd5 || pg_off_i == 3'd6) |-> pg_rdata_o == 8'd0);

  p_status_follows_dreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid_o) |-> ((($past(dreq_i, 2) >> gnt_chan_o) & 8'd1) != 8'd0));

endmodule

// File: tb/dma_req_scan_tb.sv
`timescale 1ns/1ps
module dma_req_scan_tb;
  localparam int AW = 16, CW = 16, LW = CW + 2, PW = AW + 15;
  localparam longint PMASK = (64'd1 << PW) - 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] dreq = 0, mask = 8'hFF, dec = 0;
  logic [15:0] a_arr [8];
  logic [15:0] c_arr [8];
  logic [8*AW-1:0] cur_addr;
  logic [8*CW-1:0] base_cnt;
  logic pg_we = 0, pg_hi = 0, pg_ctl = 0;
  logic [2:0] pg_off = 0;
  logic [7:0] pg_wdata = 0, pg_rdata;
  logic [LW-1:0] xpos = 0, xlen = 0, gnt_len;
  logic gnt_valid;
  logic [2:0] gnt_chan;
  logic [PW-1:0] gnt_addr, mem_addr;

  always #2 clk = ~clk;

  always_comb
    for (int g = 0; g < 8; g++) begin
      cur_addr[g*AW +: AW] = a_arr[g];
      base_cnt[g*CW +: CW] = c_arr[g];
    end

  dma_req_scan u_dut (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .mask_i(mask), .dec_i(dec),
    .cur_addr_i(cur_addr), .base_cnt_i(base_cnt), .pg_we_i(pg_we), .pg_hi_i(pg_hi),
    .pg_ctl_i(pg_ctl), .pg_off_i(pg_off), .pg_wdata_i(pg_wdata), .pg_rdata_o(pg_rdata),
    .xfer_pos_i(xpos), .xfer_len_i(xlen), .gnt_valid_o(gnt_valid), .gnt_chan_o(gnt_chan),
    .gnt_len_o(gnt_len), .gnt_addr_o(gnt_addr), .mem_addr_o(mem_addr));

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_st [8];
  int m_page [8];
  int m_hpage [8];
  int m_ptr = 0, m_gv = 0, m_gc = 0, m_gdec = 0;
  longint m_glen = 0, m_gaddr = 0;

  function automatic int chan_of(int off);
    case (off)
      7: return 0;
      3: return 1;
      1: return 2;
      2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_rd();
    int c = chan_of(pg_off);
    if (c < 0) return 0;
    c += 4 * pg_ctl;
    return pg_hi ? m_hpage[c] : m_page[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_page[i] = 0; m_hpage[i] = 0; end
      m_ptr = 0; m_gv = 0; m_gc = 0; m_gdec = 0; m_glen = 0; m_gaddr = 0;
    end else begin
      if (m_st[m_ptr] == 1 && mask[m_ptr] == 0) begin
        m_gv = 1; m_gc = m_ptr;
        m_glen = (longint'(c_arr[m_ptr]) + 1) * ((m_ptr >= 4) ? 2 : 1);
        m_gaddr = (longint'(m_hpage[m_ptr] % 128) * 64'h100_0000) +
                  (longint'(m_page[m_ptr]) * 64'h1_0000) + longint'(a_arr[m_ptr]);
        m_gdec = dec[m_ptr];
        m_ptr = 0;
      end else begin
        m_gv = 0;
        m_ptr = (m_ptr + 1) % 8;
      end
      for (int i = 0; i < 8; i++) m_st[i] = dreq[i];
      if (pg_we && chan_of(pg_off) >= 0) begin
        if (pg_hi) m_hpage[chan_of(pg_off) + 4 * pg_ctl] = pg_wdata;
        else       m_page[chan_of(pg_off) + 4 * pg_ctl] = pg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      longint ema;
      chk("R4 R5 R8 grant strobe", gnt_valid, m_gv);
      if (m_gv == 1) begin
        chk("R6 channel", gnt_chan, m_gc);
        chk("R7 length", gnt_len, m_glen);
        chk("R3 address", gnt_addr, m_gaddr);
      end
      ema = m_gdec ? (m_gaddr - xpos - xlen) & PMASK : (m_gaddr + xpos) & PMASK;
      chk("R9 memory start", mem_addr, ema);
      chk("R1 R2 page read", pg_rdata, exp_rd());
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pg_write(bit hi, bit ctl, int off, int d);
    pg_we = 1; pg_hi = hi; pg_ctl = ctl; pg_off = 3'(off); pg_wdata = 8'(d);
    step();
    pg_we = 0;
  endtask

  initial begin
    for (int g = 0; g < 8; g++) begin
      a_arr[g] = 16'(16'h1000 + g * 16'h0111);
      c_arr[g] = 16'(g * 16'h10 + 3);
    end
    c_arr[7] = 16'hFFFF;
    step(3);
    rst_n = 1;
    step();
    // R10 reset state
    chk("R10 no grant after reset", gnt_valid, 0);
    pg_ctl = 1; pg_off = 3'd3; pg_hi = 0;
    #1 chk("R10 page reads zero", pg_rdata, 0);
    cmp_on = 1;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++) begin
        pg_write(0, c[0], o, 8'h20 + c * 8 + o);
        pg_write(1, c[0], o, 8'hF8 - c * 8 - o);
      end
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++)
        for (int h = 0; h < 2; h++) begin
          pg_ctl = c[0]; pg_off = 3'(o); pg_hi = h[0];
          step();
        end
    pg_ctl = 0; pg_off = 3'd5; pg_hi = 0;
    #1 chk("R1 unmapped offset reads 0", pg_rdata, 0);
    step();
    // single channel on controller 1
    mask = 8'h00; dreq = 8'h40; step(20);
    // two channels, then mask the lower one
    dreq = 8'h42; step(20);
    mask = 8'h02; step(20);
    // release and long count on channel 7
    dreq = 8'h80; step(20);
    dreq = 8'h00; step(10);
    // decrement path
    dec = 8'h28; dreq = 8'h20; xpos = 18'd5; xlen = 18'd3; step(12);
    dreq = 8'h08; mask = 8'h00; xpos = 18'h100; xlen = 18'h20; step(12);
    dec = 8'h00; step(8);
    // mixed patterns
    for (int k = 0; k < 400; k++) begin
      if (k % 7 == 0) dreq = 8'($urandom);
      if (k % 11 == 0) mask = 8'($urandom) & 8'($urandom);
      if (k % 13 == 0) dec = 8'($urandom);
      xpos = LW'($urandom % 4096); xlen = LW'($urandom % 512);
      if (k % 17 == 0) pg_write(k[0], k[1], k % 8, $urandom % 256);
      pg_ctl = k[2]; pg_off = 3'(k % 8); pg_hi = k[3];
      step();
    end
    dreq = 0; step(4);
    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule